// File: doc/BRIEF.md
# Addressed Serial DAC Write Controller

This block takes a write request from a parallel upstream port and turns it into one serial frame for a multichannel DAC. A request carries a 5-bit channel number and a 14-bit output code. The controller joins them into a 19-bit word, with the channel first and the code after it. It sends the word most significant bit first over three wires: an active-low frame strobe, a serial clock and a data line.

The serial clock comes from the system clock. Each half-period of the serial clock lasts `HALF_DIV` system cycles. After every frame the controller holds the strobe high for at least `GAP_CYC` system cycles before it accepts the next request. The upstream side uses a valid/ready handshake. A request that arrives while a frame or gap is running waits until the block is idle again, so one frame never overlaps or cuts short another. A check at elaboration time stops the build if the parameters, for the given system clock period, break the serial-clock, half-period, idle-gap or word-rate limits.

The data line changes when the serial clock rises and holds steady when it falls, which is when the DAC samples it. The serial clock idles high.

Top module: `dac_frame_writer`

## Requirements
- R1: While reset is asserted and right after it is released: strobe_no=1, sclk_o=1, sdata_o=0, req_ready_o=1, busy_o=0 and done_o=0.
- R2: A request is taken only in a cycle with req_valid_i=1 and req_ready_o=1. The frame word is {req_chan_i, req_code_i}. Channel bit 4 is the first bit on the wire and code bit 0 is the last.
- R3: Every frame has exactly 19 falling edges of sclk_o while strobe_no=0. Whenever strobe_no=1, sclk_o is 1.
- R4: The first falling edge of sclk_o comes HALF_DIV cycles after strobe_no falls. After that, every level of sclk_o inside a frame lasts exactly HALF_DIV cycles.
- R5: Inside a frame, sdata_o changes only in a cycle where sclk_o rises. It holds steady across each falling edge.
- R6: strobe_no rises 38*HALF_DIV cycles after it fell, in the same cycle as the sclk_o rise that follows the 19th fall. done_o is high for exactly that one cycle and for no other cycle.
- R7: req_ready_o is 0 from the cycle after a request is accepted until GAP_CYC cycles after strobe_no rises. Between frames, strobe_no stays high for at least GAP_CYC+1 cycles.
- R8: Changes to the request inputs, and requests that arrive while a frame or gap is running, do not change the frame in progress. A request held valid is accepted in the first cycle req_ready_o is 1, which makes the high time between frames exactly GAP_CYC+1 cycles.
- R9: busy_o is always the inverse of req_ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_chan_i | input | 5 | Target channel number |
| req_code_i | input | 14 | Output code |
| strobe_no | output | 1 | Frame strobe, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data, MSB first |
| busy_o | output | 1 | A frame or its idle gap is running |
| done_o | output | 1 | One-cycle pulse when a frame ends |

## Verification
Two events can land in the same cycle: the idle gap running out and a request that has been waiting. The bench provokes this by keeping req_valid_i high with the next request as soon as the current one is accepted. That request then meets the cycle in which ready returns. The bench judges the result by counting how long strobe_no stays high between frames, which must be exactly GAP_CYC+1 cycles. It also decodes the next frame bit by bit to confirm that the waiting request went out whole and that the frame before it was not disturbed.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
  localparam int unsigned CHAN_W = 5;
  localparam int unsigned CODE_W = 14;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } wr_state_e;
endpackage

// File: rtl/dac_sclk_gen.sv
module dac_sclk_gen #(
  parameter int unsigned HALF_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4: half-period counter never passes its limit
  a_r4_half_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R4: counter starts from zero when a frame begins
  a_r4_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/dac_bit_shifter.sv
module dac_bit_shifter #(
  parameter int unsigned WORD_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic              fall_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam int unsigned NW = $clog2(WORD_W + 1);
  localparam logic [NW-1:0] N_LAST = NW'(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [NW-1:0]     nfall_q;

  assign msb_o  = sr_q[WORD_W-1];
  assign last_o = (nfall_q == N_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     nfall_q <= '0;
    else if (load_i) nfall_q <= '0;
    else if (fall_i) nfall_q <= nfall_q + 1'b1;
  end

  // R3: never more falls than frame bits
  a_r3_fall_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nfall_q <= N_LAST);
  // R3: no fall counted once the frame is complete
  a_r3_no_extra_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> !fall_i);
  // R5: register holds between shifts
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/dac_gap_timer.sv
module dac_gap_timer #(
  parameter int unsigned GAP_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] G_LOAD = GW'(GAP_CYC);

  logic [GW-1:0] cnt_q;

  assign expire_o = (cnt_q == GW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= G_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // R7: a running gap is never restarted
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);
  // R7: expiry is a single-cycle event
  a_r7_expire_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
  import dac_frame_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned HALF_DIV      = 3,
  parameter int unsigned GAP_CYC       = 25,
  parameter int unsigned ADDR_W        = CHAN_W,
  parameter int unsigned DATA_W        = CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_chan_i,
  input  logic [DATA_W-1:0] req_code_i,
  output logic              strobe_no,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned FRAME_W   = ADDR_W + DATA_W;
  localparam longint      HALF_PS   = longint'(HALF_DIV) * CLK_PERIOD_PS;
  localparam longint      SCLK_PS   = 2 * HALF_PS;
  localparam longint      GAP_PS    = longint'(GAP_CYC) * CLK_PERIOD_PS;
  localparam longint      WORD_PS   = longint'(2 * HALF_DIV * FRAME_W + GAP_CYC + 1) * CLK_PERIOD_PS;
  localparam longint      MIN_HALF_PS = 13000;
  localparam longint      MIN_SCLK_PS = 33334;
  localparam longint      MIN_GAP_PS  = 200000;
  localparam longint      MIN_WORD_PS = 833334;

  // elaboration-time timing limits
  if (HALF_PS < MIN_HALF_PS || SCLK_PS < MIN_SCLK_PS ||
      GAP_PS < MIN_GAP_PS || WORD_PS < MIN_WORD_PS || GAP_CYC < 1) begin : g_timing_bad
    $error("dac_frame_writer: HALF_DIV/GAP_CYC violate serial timing limits");
  end

  wr_state_e state_q;
  logic      sclk_q, sync_q, done_q;
  logic      tick, msb, last, gap_expire;
  logic      accept, do_fall, do_shift, do_end;

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = !req_ready_o;
  assign accept      = req_valid_i && req_ready_o;
  assign do_fall     = (state_q == ST_SHIFT) && tick && sclk_q;
  assign do_end      = (state_q == ST_SHIFT) && tick && !sclk_q && last;
  assign do_shift    = (state_q == ST_SHIFT) && tick && !sclk_q && !last;

  dac_sclk_gen #(.HALF_DIV(HALF_DIV)) i_sclk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SHIFT),
    .tick_o (tick)
  );

  dac_bit_shifter #(.WORD_W(FRAME_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .word_i  ({req_chan_i, req_code_i}),
    .shift_i (do_shift),
    .fall_i  (do_fall),
    .msb_o   (msb),
    .last_o  (last)
  );

  dac_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (do_end),
    .expire_o (gap_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b1;
      sync_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sync_q  <= 1'b0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
          end else begin
            sclk_q <= 1'b1;
            if (last) begin
              sync_q  <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: if (gap_expire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign strobe_no = sync_q;
  assign sclk_o    = sclk_q;
  assign sdata_o   = sync_q ? 1'b0 : msb;
  assign done_o    = done_q;

  // R3: clock idles high outside a frame
  a_r3_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_no |-> sclk_o);
  // R6: done coincides with strobe rising
  a_r6_done_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(strobe_no));
  // R6: done is one cycle wide
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7: no acceptance during the gap
  a_r7_gap_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> !req_ready_o);
  // R5: data steady while clock is low in a frame
  a_r5_data_steady_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_no && !sclk_o && !$past(sclk_o) && !$past(strobe_no)) |-> $stable(sdata_o));
  // R2: frame starts only from an accepted request
  a_r2_start_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_no) |-> $past(req_valid_i && req_ready_o));
endmodule

// File: tb/test_dac_frame_writer.sv
module test_dac_frame_writer;
  localparam int H   = 3;
  localparam int GAP = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  chan = '0;
  logic [13:0] code = '0;
  logic        ready, strobe_n, sclk, sdata, busy, done;

  int total = 0;
  int bad   = 0;
  int frames = 0;
  int pushed = 0;
  bit b2b = 0;
  logic [18:0] exp_q [0:7];
  int rd_p = 0;

  always #4 clk = ~clk;

  dac_frame_writer #(.CLK_PERIOD_PS(8000), .HALF_DIV(H), .GAP_CYC(GAP)) i_dac_frame_writer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_chan_i(chan), .req_code_i(code), .strobe_no(strobe_n),
    .sclk_o(sclk), .sdata_o(sdata), .busy_o(busy), .done_o(done));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor, sampled on the falling clock edge
  logic p_sclk = 1'b1, p_sync = 1'b1, p_sdata = 1'b0;
  int   cyc_edge = 0, cyc_frame = 0, falls = 0, high_len = 0;
  logic [18:0] word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == !ready, "R9 busy/ready", busy, !ready);
      if (p_sync && !strobe_n) begin
        if (frames > 0) begin
          chk(high_len >= GAP + 1, "R7 gap length", high_len, GAP + 1);
          if (b2b) chk(high_len == GAP + 1, "R8 held request latency", high_len, GAP + 1);
        end
        cyc_edge = 0; cyc_frame = 0; falls = 0; word = '0;
      end else if (!strobe_n) begin
        cyc_edge++; cyc_frame++;
        if (p_sclk && !sclk) begin
          chk(cyc_edge == H, "R4 half period", cyc_edge, H);
          word = {word[17:0], sdata};
          falls++;
          cyc_edge = 0;
        end else if (!p_sclk && sclk) begin
          chk(cyc_edge == H, "R4 half period", cyc_edge, H);
          cyc_edge = 0;
        end else begin
          chk(sdata == p_sdata, "R5 data change off rise", sdata, p_sdata);
        end
        chk(!done, "R6 done inside frame", done, 0);
      end else if (!p_sync && strobe_n) begin
        chk(cyc_frame + 1 == 38 * H, "R6 frame length", cyc_frame + 1, 38 * H);
        chk(!p_sclk && sclk && cyc_edge + 1 == H, "R6 rise with last sclk", cyc_edge + 1, H);
        chk(done, "R6 done pulse", done, 1);
        chk(falls == 19, "R3 fall count", falls, 19);
        chk(word == exp_q[rd_p % 8], "R2 frame word", word, exp_q[rd_p % 8]);
        rd_p++; frames++; high_len = 1;
      end else begin
        high_len++;
        chk(sclk, "R3 sclk idle high", sclk, 1);
        chk(!done, "R6 done outside end", done, 0);
      end
      p_sclk = sclk; p_sync = strobe_n; p_sdata = sdata;
    end
  end

  task automatic send(input logic [4:0] c, input logic [13:0] d);
    valid = 1'b1; chan = c; code = d;
    while (!ready) @(negedge clk);
    exp_q[pushed % 8] = {c, d};
    pushed++;
    @(negedge clk);
    chk(!ready && busy, "R7 ready low after accept", ready, 0);
    valid = 1'b0;
    chan = ~c; code = ~d ^ 14'h1234;  // R8 disturbance
  endtask

  task automatic drain();
    while (!(ready && frames == pushed)) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(strobe_n && sclk && !sdata && ready && !busy && !done, "R1 reset state",
        {strobe_n, sclk, sdata, ready, busy, done}, 6'b110100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe_n && sclk && !sdata && ready && !busy && !done, "R1 after release",
        {strobe_n, sclk, sdata, ready, busy, done}, 6'b110100);
    // R2: valid without ready never happens here; valid low leaves line idle
    repeat (5) @(negedge clk);
    chk(strobe_n && frames == 0, "R2 no start without valid", strobe_n, 1);

    // R8: back-to-back sweep of every channel, request held during frames
    b2b = 1;
    for (int ch = 0; ch < 32; ch++) send(5'(ch), 14'((ch * 517 + 123) & 16'h3fff));
    drain();
    b2b = 0;
    // R2: walking-one codes, spaced requests
    for (int b = 0; b < 14; b++) begin
      repeat (b + 3) @(negedge clk);
      send(5'(31 - b), 14'(1 << b));
      drain();
    end
    // R2: boundary codes
    send(5'h00, 14'h0000); drain();
    send(5'h1f, 14'h3fff); drain();
    send(5'h15, 14'h2aaa); drain();
    send(5'h0a, 14'h1555); drain();
    chk(frames == pushed, "R3 frames sent", frames, pushed);
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R3 act=%0d exp=%0d", frames, pushed);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule